// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block takes the refresh duty away from an SDRAM controller. A free-running interval timer produces one refresh credit per refresh period. Credits gather in a saturating pending counter. While credits are outstanding, the sequencer asks the controller's arbiter for the command bus. The arbiter answers with a grant once every bank has been closed.

After the grant, the sequencer takes the bus. It waits out the precharge time and issues one auto-refresh. It then drives NOPs for the rest of the refresh cycle time. Finally it hands the bus back with a one-cycle done pulse.

A power-management request follows the same grant path, but the command it issues is a self-refresh entry, so the clock enable goes low. The sequencer keeps the clock enable low until the clock-stop logic reports that the clock runs again. It then raises the clock enable and waits an exit recovery time before it reports done. When credits reach the limit, an urgent flag rises and the next refresh takes priority over everything else.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and right after reset, no request and no done are raised, the bus is not owned, and the command pins show deselect (cs_n=1, ras_n=1, cas_n=1, we_n=1) with cke=1.
- R2: The interval timer adds one pending credit every REFI_CYC cycles. The count saturates at MAX_PEND, and ref_urgent is high exactly while the count equals MAX_PEND.
- R3: An auto-refresh is driven for exactly one cycle as cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1, and cke was high in the cycle before it.
- R4: After a grant is sampled, NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1) is driven for TRP_CYC cycles before the refresh or self-refresh command.
- R5: After an auto-refresh, NOP is driven for TRC_CYC-1 cycles. This is followed by one cycle with ref_done=1 and bus_own=0.
- R6: ref_req stays high from the cycle after a request is decided until a grant is sampled. A grant sampled while ref_req is low has no effect.
- R7: When idle, the sequencer makes its choice in this order: a saturated credit count starts an auto-refresh, otherwise sr_enter starts self-refresh, otherwise a nonzero count starts an auto-refresh.
- R8: Self-refresh entry is driven for one cycle as cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0. After that, cke stays 0 with deselect on the other pins until sr_exit is sampled high.
- R9: After sr_exit is sampled, cke=1 with NOP is driven for XSR_CYC cycles. This is followed by one done cycle.
- R10: Each auto-refresh removes one credit. Self-refresh entry clears all credits, and the interval timer stays at zero until the exit recovery ends.
- R11: bus_own is high exactly during the precharge wait, the command cycles, the refresh cycle wait and the self-refresh hold and recovery. In all other cycles it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Arbiter grant: all banks closed, bus handed over |
| sr_enter | input | 1 | Power-management request to enter self-refresh (level) |
| sr_exit | input | 1 | Clock running again, leave self-refresh (level) |
| ref_req | output | 1 | Request for the command bus |
| ref_done | output | 1 | One-cycle pulse: bus returned |
| ref_urgent | output | 1 | Credit count saturated |
| bus_own | output | 1 | Sequencer drives the command pins |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable |

## Verification
Every output is a direct decode of the sequencer state. A grant, sr_enter or sr_exit sampled at one rising edge therefore changes the pins in the very next cycle. A timer tick shows up in ref_urgent and in the following request one edge later. The precharge wait, the refresh-cycle wait and the recovery wait then run for their programmed counts in whole cycles. The bench drives inputs on the falling edge. It advances a behavioural reference model on the rising edge and compares every output on the next falling edge, so each result is checked in the exact cycle it is due. Directed checks add the saturated-credit ordering, the ignored grant and the credit clearing after self-refresh.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_AR_REQ,
        ST_AR_TRP,
        ST_AR_CMD,
        ST_AR_TRC,
        ST_SR_REQ,
        ST_SR_TRP,
        ST_SR_CMD,
        ST_SR_HOLD,
        ST_SR_XSR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESEL    = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam sdr_cmd_t CMD_NOP      = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1};
    localparam sdr_cmd_t CMD_AUTO_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b1};
    localparam sdr_cmd_t CMD_SELF_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, cke: 1'b0};
    localparam sdr_cmd_t CMD_SR_KEEP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b0};

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic sdr_cmd_t state_cmd(seq_state_e s);
        case (s)
            ST_AR_TRP, ST_AR_TRC,
            ST_SR_TRP, ST_SR_XSR: return CMD_NOP;
            ST_AR_CMD:            return CMD_AUTO_REF;
            ST_SR_CMD:            return CMD_SELF_REF;
            ST_SR_HOLD:           return CMD_SR_KEEP;
            default:              return CMD_DESEL;
        endcase
    endfunction

    function automatic logic state_owns_bus(seq_state_e s);
        case (s)
            ST_AR_TRP, ST_AR_CMD, ST_AR_TRC,
            ST_SR_TRP, ST_SR_CMD, ST_SR_HOLD, ST_SR_XSR: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    function automatic logic state_in_self_ref(seq_state_e s);
        return (s == ST_SR_CMD) || (s == ST_SR_HOLD) || (s == ST_SR_XSR);
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned REFI_CYC = 2200
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_clear,
    output logic tick
);
    localparam int unsigned TW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign tick = !hold_clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold_clear) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic any,
    output logic full
);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

    logic [PW-1:0] cnt_q;

    assign any  = (cnt_q != '0);
    assign full = (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !dec && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && any) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r2_sat_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !dec && !clr) |=> full);

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> !any);

endmodule

// File: rtl/ref_wait_ctr.sv
module ref_wait_ctr #(
    parameter int unsigned WW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    output logic          zero
);
    logic [WW-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r4_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int unsigned REFI_CYC = 2200,
    parameter int unsigned TRP_CYC  = 3,
    parameter int unsigned TRC_CYC  = 9,
    parameter int unsigned XSR_CYC  = 10,
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_grant,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_done,
    output logic ref_urgent,
    output logic bus_own,
    output logic cmd_cs_n,
    output logic cmd_ras_n,
    output logic cmd_cas_n,
    output logic cmd_we_n,
    output logic cmd_cke
);
    localparam int unsigned WMAX = max3(TRP_CYC, TRC_CYC, XSR_CYC);
    localparam int unsigned WW   = $clog2(WMAX + 1);
    localparam logic [WW-1:0] LD_TRP = WW'(TRP_CYC - 1);
    localparam logic [WW-1:0] LD_TRC = WW'(TRC_CYC - 2);
    localparam logic [WW-1:0] LD_XSR = WW'(XSR_CYC - 1);

    seq_state_e    state_q, state_d;
    logic          tick, pend_any, pend_full;
    logic          wait_zero, wait_load;
    logic [WW-1:0] wait_val;
    sdr_cmd_t      cmd;

    ref_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .hold_clear (state_in_self_ref(state_q)),
        .tick       (tick)
    );

    ref_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .clr  (state_q == ST_SR_CMD),
        .inc  (tick),
        .dec  (state_q == ST_AR_CMD),
        .any  (pend_any),
        .full (pend_full)
    );

    ref_wait_ctr #(.WW(WW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    always_comb begin
        state_d   = state_q;
        wait_load = 1'b0;
        wait_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (pend_full)     state_d = ST_AR_REQ;
                else if (sr_enter) state_d = ST_SR_REQ;
                else if (pend_any) state_d = ST_AR_REQ;
            end
            ST_AR_REQ: if (ref_grant) begin
                state_d = ST_AR_TRP; wait_load = 1'b1; wait_val = LD_TRP;
            end
            ST_AR_TRP: if (wait_zero) state_d = ST_AR_CMD;
            ST_AR_CMD: begin
                state_d = ST_AR_TRC; wait_load = 1'b1; wait_val = LD_TRC;
            end
            ST_AR_TRC: if (wait_zero) state_d = ST_DONE;
            ST_SR_REQ: if (ref_grant) begin
                state_d = ST_SR_TRP; wait_load = 1'b1; wait_val = LD_TRP;
            end
            ST_SR_TRP: if (wait_zero) state_d = ST_SR_CMD;
            ST_SR_CMD: state_d = ST_SR_HOLD;
            ST_SR_HOLD: if (sr_exit) begin
                state_d = ST_SR_XSR; wait_load = 1'b1; wait_val = LD_XSR;
            end
            ST_SR_XSR: if (wait_zero) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign cmd        = state_cmd(state_q);
    assign cmd_cs_n   = cmd.cs_n;
    assign cmd_ras_n  = cmd.ras_n;
    assign cmd_cas_n  = cmd.cas_n;
    assign cmd_we_n   = cmd.we_n;
    assign cmd_cke    = cmd.cke;
    assign bus_own    = state_owns_bus(state_q);
    assign ref_req    = (state_q == ST_AR_REQ) || (state_q == ST_SR_REQ);
    assign ref_done   = (state_q == ST_DONE);
    assign ref_urgent = pend_full;

    // R3: refresh only with the clock enable already high
    a_r3_cke_before_ar: assert property (@(posedge clk) disable iff (rst)
        (!cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && cmd_cke) |-> $past(cmd_cke));

    a_r8_cke_held_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SR_HOLD && !sr_exit) |=> !cmd_cke);

    a_r6_req_until_grant: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_grant) |=> ref_req);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> !ref_done);

    a_r4_wait_before_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_own) |-> (!cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n && cmd_cke));

endmodule

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;
    localparam int REFI = 40;
    localparam int TRP  = 3;
    localparam int TRC  = 6;
    localparam int TXSR = 5;
    localparam int MAXP = 8;

    localparam int P_IDLE = 0, P_AREQ = 1, P_ATRP = 2, P_ACMD = 3, P_ATRC = 4,
                   P_SREQ = 5, P_STRP = 6, P_SCMD = 7, P_SHOLD = 8, P_SXSR = 9, P_DONE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_done, ref_urgent, bus_own;
    logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke;

    int checks = 0, failures = 0, cyc = 0;
    bit auto_grant = 1'b0;

    int ph = 0, el = 0, mpend = 0, mtimer = 0;

    always #10 clk = ~clk;

    sdram_refresh_seq #(
        .REFI_CYC(REFI), .TRP_CYC(TRP), .TRC_CYC(TRC), .XSR_CYC(TXSR), .MAX_PEND(MAXP)
    ) dut (
        .clk(clk), .rst(rst), .ref_grant(ref_grant), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .ref_req(ref_req), .ref_done(ref_done), .ref_urgent(ref_urgent), .bus_own(bus_own),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_cke(cmd_cke)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            ph = P_IDLE; el = 0; mpend = 0; mtimer = 0;
        end else begin
            int nph;
            bit frz, tk;
            frz = (ph == P_SCMD) || (ph == P_SHOLD) || (ph == P_SXSR);
            tk  = !frz && (mtimer == REFI - 1);
            nph = ph;
            case (ph)
                P_IDLE:  if (mpend == MAXP) nph = P_AREQ;
                         else if (sr_enter) nph = P_SREQ;
                         else if (mpend > 0) nph = P_AREQ;
                P_AREQ:  if (ref_grant) nph = P_ATRP;
                P_ATRP:  if (el == TRP - 1) nph = P_ACMD;
                P_ACMD:  nph = P_ATRC;
                P_ATRC:  if (el == TRC - 2) nph = P_DONE;
                P_SREQ:  if (ref_grant) nph = P_STRP;
                P_STRP:  if (el == TRP - 1) nph = P_SCMD;
                P_SCMD:  nph = P_SHOLD;
                P_SHOLD: if (sr_exit) nph = P_SXSR;
                P_SXSR:  if (el == TXSR - 1) nph = P_DONE;
                default: nph = P_IDLE;
            endcase
            el = (nph == ph) ? el + 1 : 0;
            if (ph == P_SCMD) mpend = 0;
            else if (tk && ph != P_ACMD && mpend < MAXP) mpend = mpend + 1;
            else if (!tk && ph == P_ACMD) mpend = mpend - 1;
            mtimer = frz ? 0 : ((mtimer == REFI - 1) ? 0 : mtimer + 1);
            ph = nph;
        end
    end

    function automatic logic [4:0] exp_cmd(int p);
        case (p)
            P_ATRP, P_ATRC, P_STRP, P_SXSR: return 5'b01111;
            P_ACMD:  return 5'b00011;
            P_SCMD:  return 5'b00010;
            P_SHOLD: return 5'b11110;
            default: return 5'b11111;
        endcase
    endfunction

    function automatic string tag_of(int p);
        case (p)
            P_ATRP, P_STRP:  return "R4";
            P_ACMD:          return "R3";
            P_ATRC, P_DONE:  return "R5";
            P_SCMD, P_SHOLD: return "R8";
            P_SXSR:          return "R9";
            P_AREQ, P_SREQ:  return "R6";
            default:         return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic compare();
        logic [4:0] a, e;
        bit own_e;
        a = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke};
        e = exp_cmd(ph);
        own_e = !(ph == P_IDLE || ph == P_AREQ || ph == P_SREQ || ph == P_DONE);
        check(a == e, tag_of(ph), "cmd", int'(a), int'(e));
        check(bus_own == own_e, "R11", "bus_own", int'(bus_own), int'(own_e));
        check(ref_req == (ph == P_AREQ || ph == P_SREQ), "R6", "ref_req",
              int'(ref_req), int'(ph == P_AREQ || ph == P_SREQ));
        check(ref_done == (ph == P_DONE), "R5", "ref_done", int'(ref_done), int'(ph == P_DONE));
        check(ref_urgent == (mpend == MAXP), "R2", "ref_urgent", int'(ref_urgent), int'(mpend == MAXP));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst) compare();
            if (auto_grant) ref_grant = ref_req;
        end
    endtask

    function automatic bit is_ar();
        return !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n && cmd_cke;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit seen_ar;
        @(negedge clk);
        // R1: reset state
        check({ref_req, ref_done, bus_own} == 3'b000, "R1", "handshake", int'({ref_req, ref_done, bus_own}), 0);
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke} == 5'b11111, "R1", "cmd",
              int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke}), 31);
        step(3);
        rst = 1'b0;

        // R6: a grant while no request is pending does nothing
        ref_grant = 1'b1;
        step(25);
        check(!bus_own && cmd_cs_n, "R6", "idle_grant_bus", int'(bus_own), 0);
        ref_grant = 1'b0;

        // regular refreshes with prompt grants
        auto_grant = 1'b1;
        step(200);

        // withhold grants until credits saturate (R2)
        auto_grant = 1'b0;
        ref_grant  = 1'b0;
        step(9 * REFI + 5);
        check(ref_urgent == 1'b1, "R2", "saturated", int'(ref_urgent), 1);
        check(ref_req == 1'b1, "R6", "req_held", int'(ref_req), 1);
        auto_grant = 1'b1;
        step(220);

        // self-refresh entry and exit
        sr_enter = 1'b1;
        while (cmd_cke) step(1);
        sr_enter = 1'b0;
        step(30);
        check(cmd_cke == 1'b0, "R8", "cke_low_hold", int'(cmd_cke), 0);
        sr_exit = 1'b1;
        step(1);
        sr_exit = 1'b0;
        step(TXSR + 10);

        // R7: saturated credits win over self-refresh, then self-refresh wins
        auto_grant = 1'b0;
        ref_grant  = 1'b0;
        step(9 * REFI + 5);
        sr_enter   = 1'b1;
        auto_grant = 1'b1;
        seen_ar    = 1'b0;
        while (cmd_cke) begin
            if (is_ar()) seen_ar = 1'b1;
            step(1);
        end
        sr_enter = 1'b0;
        check(seen_ar, "R7", "urgent_first", int'(seen_ar), 1);
        step(20);
        sr_exit = 1'b1;
        step(1);
        sr_exit = 1'b0;
        step(TXSR + 3);
        // R10: credits cleared by self-refresh
        check(ref_urgent == 1'b0 && ref_req == 1'b0, "R10", "cleared", int'(ref_urgent), 0);
        step(REFI + 30);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule